// File: doc/BRIEF.md
# Modem-Handshake Transmit Gate

This block sits beside one bit-oriented framed transmitter and decides when that transmitter may put a frame on the line. When the host side reports a pending frame, the block drives an active-low request-to-send line. It then holds the transmitter off until the modem answers with an active-low clear-to-send. The clear-to-send input comes from another clock domain, so a two-stage synchronizer brings it in first.

If clear-to-send goes away while a frame is on the line, the transmitter is stopped at once and the line idles. What happens next depends on how many information-field bytes had already left. Below the limit, the block keeps its request up and waits for permission to return. It then restarts the frame itself with a one-cycle restart pulse, and the host is not involved. At or past the limit, the block pulses a transmit-FIFO reset and an interrupt, drops its request and goes back to idle. Software can force the request-to-send pin to either level. This override acts on the pin only and leaves the sequencing unchanged.

Top module: `tx_handshake_ctrl`

## Requirements
- R1: During reset and right after it, `rts_n_o` is 1 and `tx_en_o`, `restart_o`, `fifo_rst_o` and `irq_o` are all 0.
- R2: While a frame is pending, requested, being sent or held, `rts_n_o` is driven low (0). When there is no override, an idle block drives it high (1).
- R3: `tx_en_o` is 1 only while clear-to-send grants permission (`cts_n_i` = 0 as seen through the synchronizer). While the request is waiting for a grant, it stays 0.
- R4: A change on `cts_n_i` reaches `tx_en_o` on the third rising clock edge after the input changes: two synchronizer stages plus the state register.
- R5: Suppose clear-to-send is withdrawn while sending, with fewer than 32 information bytes counted. Then `tx_en_o` falls to 0, `rts_n_o` stays 0, and neither `fifo_rst_o` nor `irq_o` is raised.
- R6: Suppose permission returns while a frame is held. Then `tx_en_o` rises and `restart_o` is 1 for exactly one cycle, the first cycle of the resent frame. The byte counts start again from zero.
- R7: The first HDR_BYTES (default 2) byte strobes of a frame are address/control and are not counted. Suppose clear-to-send is withdrawn once 32 or more information bytes have been counted. Then `fifo_rst_o` and `irq_o` are 1 for exactly one cycle, `rts_n_o` is 1 and `tx_en_o` is 0. After that the block is idle.
- R8: The information-byte counter saturates at 32. Byte strobes outside the sending state are ignored.
- R9: When `sw_rts_en_i` = 1, `rts_n_o` equals the inverse of `sw_rts_val_i`, and the request/send sequencing is not affected.
- R10: `eof_i` in the sending state ends the frame. If `frame_pend_i` = 0 at that cycle, `rts_n_o` is released to 1. If it is 1, the request stays low and the next frame waits for a grant again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_pend_i | input | 1 | A frame is waiting in the transmit FIFO |
| cts_n_i | input | 1 | Clear-to-send from the modem, active low, asynchronous |
| byte_sent_i | input | 1 | One-cycle strobe per byte shifted out by the serializer |
| eof_i | input | 1 | Closing flag of the current frame has been sent |
| sw_rts_en_i | input | 1 | Software takes control of the request-to-send pin |
| sw_rts_val_i | input | 1 | Software request level (1 = request, pin driven low) |
| rts_n_o | output | 1 | Request-to-send to the modem, active low |
| tx_en_o | output | 1 | Serializer may send; 0 makes the line idle |
| restart_o | output | 1 | One-cycle pulse: resend the held frame from its start |
| fifo_rst_o | output | 1 | One-cycle pulse: flush the transmit FIFO and transmitter |
| irq_o | output | 1 | One-cycle interrupt pulse to the host on unrecoverable loss |

## Verification
The hardest situation to reach is the boundary between self-recovery and failure. Clear-to-send has to be withdrawn after exactly 31 and then exactly 32 information bytes, with the address/control bytes excluded from the count. It also has to happen after an earlier abort and restart, which must have cleared the count. The stimulus first sends a short frame and aborts it. It then pours strobes into the held state, restores permission, and sends header plus 31 bytes before withdrawing permission again. The expected result is a hold, not a failure. A second restart is followed by header plus 32 bytes, and there the failure pulse is expected.

// File: rtl/tx_handshake_pkg.sv
package tx_handshake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_SEND = 3'd2,
    ST_HOLD = 3'd3,
    ST_FAIL = 3'd4
  } txh_state_e;

endpackage

// File: rtl/txh_sync.sv
module txh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q[1] == $past(chain_q[0])) else $error("sync stage skipped"); // R4

endmodule

// File: rtl/txh_info_cnt.sv
module txh_info_cnt #(
  parameter int HDR_BYTES  = 2,
  parameter int INFO_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic cnt_en_i,
  input  logic byte_stb_i,
  output logic at_limit_o
);

  localparam int HW = $clog2(HDR_BYTES + 1);
  localparam int CW = $clog2(INFO_LIMIT + 1);
  localparam logic [HW-1:0] HDR_LAST = HW'(HDR_BYTES);
  localparam logic [CW-1:0] INFO_MAX = CW'(INFO_LIMIT);

  logic [HW-1:0] hdr_q, hdr_d;
  logic [CW-1:0] info_q, info_d;
  logic          hdr_done;
  logic          step;

  always_comb begin
    hdr_done = (hdr_q == HDR_LAST);
    step     = cnt_en_i && byte_stb_i;
    hdr_d    = hdr_q;
    info_d   = info_q;
    if (clr_i) begin
      hdr_d  = '0;
      info_d = '0;
    end else if (step) begin
      if (!hdr_done) begin
        hdr_d = hdr_q + HW'(1);
      end else if (info_q != INFO_MAX) begin
        info_d = info_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      info_q <= '0;
    end else begin
      hdr_q  <= hdr_d;
      info_q <= info_d;
    end
  end

  assign at_limit_o = (info_q == INFO_MAX);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    info_q <= INFO_MAX) else $error("info count overran"); // R8
  AST_CNT_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i && !clr_i) |=> $stable(info_q)) else $error("count moved while disabled"); // R8
  AST_CNT_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (info_q != '0) |-> (hdr_q == HDR_LAST)) else $error("info counted before header"); // R7

endmodule

// File: rtl/txh_fsm.sv
module txh_fsm
  import tx_handshake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cts_ok_i,
  input  logic frame_pend_i,
  input  logic eof_i,
  input  logic at_limit_i,
  output logic rts_req_o,
  output logic tx_en_o,
  output logic restart_o,
  output logic fail_o,
  output logic cnt_clr_o,
  output logic cnt_en_o
);

  txh_state_e state_q, state_d;
  logic       restart_q, restart_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (frame_pend_i) state_d = ST_REQ;
      ST_REQ:  if (cts_ok_i)     state_d = ST_SEND;
      ST_SEND: begin
        if (!cts_ok_i) begin
          state_d = at_limit_i ? ST_FAIL : ST_HOLD;
        end else if (eof_i) begin
          state_d = frame_pend_i ? ST_REQ : ST_IDLE;
        end
      end
      ST_HOLD: if (cts_ok_i)     state_d = ST_SEND;
      ST_FAIL:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
    restart_d = (state_q == ST_HOLD) && cts_ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

  always_comb begin
    rts_req_o = (state_q == ST_REQ) || (state_q == ST_SEND) || (state_q == ST_HOLD);
    tx_en_o   = (state_q == ST_SEND);
    fail_o    = (state_q == ST_FAIL);
    cnt_en_o  = (state_q == ST_SEND);
    cnt_clr_o = (state_q != ST_SEND);
    restart_o = restart_q;
  end

  AST_SEND_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND) |-> $past(cts_ok_i)) else $error("sending without grant"); // R3
  AST_DROP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && !cts_ok_i) |=> (state_q != ST_SEND)) else $error("late stop"); // R5
  AST_RESTART_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> $past(state_q == ST_HOLD)) else $error("restart without hold"); // R6
  AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL) |=> (state_q == ST_IDLE)) else $error("fail lingered"); // R7
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL) |-> $past(at_limit_i)) else $error("fail below limit"); // R7

endmodule

// File: rtl/tx_handshake_ctrl.sv
module tx_handshake_ctrl #(
  parameter int HDR_BYTES   = 2,
  parameter int INFO_LIMIT  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pend_i,
  input  logic cts_n_i,
  input  logic byte_sent_i,
  input  logic eof_i,
  input  logic sw_rts_en_i,
  input  logic sw_rts_val_i,
  output logic rts_n_o,
  output logic tx_en_o,
  output logic restart_o,
  output logic fifo_rst_o,
  output logic irq_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       cts_n_sync;
  logic       cts_ok;
  logic       at_limit;
  logic       rts_req;
  logic       fail;
  logic       cnt_clr;
  logic       cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  txh_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (cts_n_i),
    .q_o   (cts_n_sync)
  );
  assign cts_ok = !cts_n_sync;

  txh_info_cnt #(
    .HDR_BYTES  (HDR_BYTES),
    .INFO_LIMIT (INFO_LIMIT)
  ) u_info_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (cnt_clr),
    .cnt_en_i   (cnt_en),
    .byte_stb_i (byte_sent_i),
    .at_limit_o (at_limit)
  );

  txh_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cts_ok_i     (cts_ok),
    .frame_pend_i (frame_pend_i),
    .eof_i        (eof_i),
    .at_limit_i   (at_limit),
    .rts_req_o    (rts_req),
    .tx_en_o      (tx_en_o),
    .restart_o    (restart_o),
    .fail_o       (fail),
    .cnt_clr_o    (cnt_clr),
    .cnt_en_o     (cnt_en)
  );

  always_comb begin
    rts_n_o    = sw_rts_en_i ? !sw_rts_val_i : !rts_req;
    fifo_rst_o = fail;
    irq_o      = fail;
  end

  AST_PULSE_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_rst_o == irq_o) else $error("reset and irq split"); // R7
  AST_TXEN_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_en_o && !sw_rts_en_i) |-> !rts_n_o) else $error("sending without request"); // R2
  AST_OVERRIDE_PIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_rts_en_i |-> (rts_n_o == !sw_rts_val_i)) else $error("override ignored"); // R9

endmodule

// File: tb/tx_handshake_ctrl_tb.sv
module tx_handshake_ctrl_tb;

  localparam int HDR = 2;

  logic clk;
  logic rst_n;
  logic frame_pend, cts_n, byte_sent, eof, sw_en, sw_val;
  logic rts_n, tx_en, restart, fifo_rst, irq;
  int   n_chk;
  int   n_bad;

  tx_handshake_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pend_i (frame_pend),
    .cts_n_i      (cts_n),
    .byte_sent_i  (byte_sent),
    .eof_i        (eof),
    .sw_rts_en_i  (sw_en),
    .sw_rts_val_i (sw_val),
    .rts_n_o      (rts_n),
    .tx_en_o      (tx_en),
    .restart_o    (restart),
    .fifo_rst_o   (fifo_rst),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) byte_sent = 1'b1;
    end
    @(negedge clk) byte_sent = 1'b0;
  endtask

  task automatic start_frame();
    @(negedge clk) frame_pend = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3", "tx_en after grant", tx_en, 1'b1);
  endtask

  task automatic drop_cts();
    @(negedge clk) cts_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic give_cts();
    @(negedge clk) cts_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic end_frame(input logic more);
    @(negedge clk) begin eof = 1'b1; frame_pend = more; end
    @(negedge clk) eof = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "rts_n", rts_n, 1'b1);
    chk("R1", "tx_en", tx_en, 1'b0);
    chk("R1", "restart", restart, 1'b0);
    chk("R1", "fifo_rst", fifo_rst, 1'b0);
    chk("R1", "irq", irq, 1'b0);
  endtask

  task automatic t_handshake();
    @(negedge clk) frame_pend = 1'b1;
    @(negedge clk);
    chk("R2", "rts_n on request", rts_n, 1'b0);
    repeat (4) @(negedge clk);
    chk("R3", "tx_en without grant", tx_en, 1'b0);
    cts_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4", "tx_en after two edges", tx_en, 1'b0);
    @(negedge clk);
    chk("R4", "tx_en after three edges", tx_en, 1'b1);
    send_bytes(HDR + 5);
    end_frame(1'b0);
    chk("R10", "rts_n released", rts_n, 1'b1);
    chk("R10", "tx_en off", tx_en, 1'b0);
    chk("R2", "idle rts_n", rts_n, 1'b1);
  endtask

  task automatic t_back_to_back();
    start_frame();
    send_bytes(3);
    end_frame(1'b1);
    chk("R10", "rts_n kept", rts_n, 1'b0);
    chk("R10", "tx_en gap", tx_en, 1'b0);
    @(negedge clk);
    chk("R10", "next frame sends", tx_en, 1'b1);
    send_bytes(4);
    end_frame(1'b0);
    chk("R10", "rts_n released after second", rts_n, 1'b1);
  endtask

  task automatic t_boundary();
    start_frame();
    frame_pend = 1'b0;
    send_bytes(HDR + 10);
    drop_cts();
    chk("R5", "tx_en idle", tx_en, 1'b0);
    chk("R5", "rts_n held", rts_n, 1'b0);
    chk("R5", "irq", irq, 1'b0);
    chk("R5", "fifo_rst", fifo_rst, 1'b0);
    send_bytes(40);
    chk("R8", "irq after hold strobes", irq, 1'b0);
    give_cts();
    chk("R6", "restart pulse", restart, 1'b1);
    chk("R6", "tx_en resumed", tx_en, 1'b1);
    @(negedge clk);
    chk("R6", "restart one cycle", restart, 1'b0);
    send_bytes(HDR + 31);
    drop_cts();
    chk("R7", "31 bytes: irq", irq, 1'b0);
    chk("R7", "31 bytes: fifo_rst", fifo_rst, 1'b0);
    chk("R8", "31 bytes: rts_n held", rts_n, 1'b0);
    give_cts();
    chk("R6", "second restart", restart, 1'b1);
    send_bytes(HDR + 32);
    drop_cts();
    chk("R7", "32 bytes: fifo_rst", fifo_rst, 1'b1);
    chk("R7", "32 bytes: irq", irq, 1'b1);
    chk("R7", "32 bytes: rts_n", rts_n, 1'b1);
    chk("R7", "32 bytes: tx_en", tx_en, 1'b0);
    @(negedge clk);
    chk("R7", "fail pulse ends", irq, 1'b0);
    chk("R7", "fifo_rst ends", fifo_rst, 1'b0);
    chk("R7", "idle rts_n", rts_n, 1'b1);
    give_cts();
  endtask

  task automatic t_saturate();
    start_frame();
    frame_pend = 1'b0;
    send_bytes(HDR + 45);
    chk("R8", "no irq while sending", irq, 1'b0);
    drop_cts();
    chk("R8", "saturated count fails", irq, 1'b1);
    @(negedge clk);
    chk("R8", "back to idle", rts_n, 1'b1);
    give_cts();
  endtask

  task automatic t_override();
    @(negedge clk) begin sw_en = 1'b1; sw_val = 1'b1; end
    @(negedge clk);
    chk("R9", "forced request", rts_n, 1'b0);
    chk("R9", "no send when forced", tx_en, 1'b0);
    sw_val = 1'b0;
    start_frame();
    chk("R9", "forced release", rts_n, 1'b1);
    @(negedge clk) sw_en = 1'b0;
    @(negedge clk);
    chk("R9", "auto request back", rts_n, 1'b0);
    end_frame(1'b0);
    chk("R9", "auto release", rts_n, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    frame_pend = 1'b0;
    cts_n = 1'b1;
    byte_sent = 1'b0;
    eof = 1'b0;
    sw_en = 1'b0;
    sw_val = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_handshake();
    t_back_to_back();
    t_boundary();
    t_saturate();
    t_override();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule